// File: doc/BRIEF.md
# Legacy-Aware I/O Bus Target

This block is a synchronous target on a multiplexed address/data bus in the PCI style. It serves single-beat I/O reads and writes and hands each one to a slow register back end through a request/acknowledge port. Every address phase is examined. An address inside one of the configured windows is claimed positively with medium decode timing, one clock later than the fastest possible claim. Any other address can be taken as a late subtractive claim, but only once the positive decode window has passed and no other agent has signalled device-select. The subtractive claim can be switched off by a configuration input.

After claiming, the target has a fixed number of clocks to present data. When the back end misses that deadline, the target signals retry and ends the cycle. The back-end request keeps running and its result is held. When the master repeats the same access, it completes from the held result and no second back-end access is made. Subtractive accesses are reduced to one byte lane for eight-bit legacy peripherals. Each cycle ends with one clock in which the control strobes are driven inactive, then an idle clock before the strobes are released.

Top module: `io_bus_target`

## Requirements
- R1: Out of reset, tgt_sel, tgt_rdy, tgt_retry, tgt_ctl_oe, bus_ad_oe and be_req are all low.
- R2: If bus_start is high in cycle A and bus_ad_in falls inside any configured window (own range 0xE400-0xE43F or compatibility range 0x0060-0x006F by default), tgt_sel first goes high in cycle A+2 and the back-end access carries be_legacy=0. This holds whether or not subtractive decode is enabled.
- R3: With cfg_sub_en high, an address outside every window is claimed in cycle A+3 with be_legacy=1, but only if other_sel was low in both A+1 and A+2. Otherwise tgt_sel stays low and no back-end access is made.
- R4: With cfg_sub_en low, an address outside every window is ignored: tgt_sel stays low and be_req never rises.
- R5: With claim cycle C, an acknowledge sampled at the end of cycle C+k (k from 0 to 7) gives tgt_rdy in cycle C+k+1. On a read, bus_ad_oe is high and bus_ad_out holds the back-end data in that cycle only. The shortest access is therefore four clocks from the address phase.
- R6: If no acknowledge is sampled by the end of cycle C+7, tgt_retry is high in cycle C+8 and tgt_rdy stays low.
- R7: bus_be bit i enables byte lane i (active high). A positive claim passes bus_be to be_be unchanged. A subtractive claim passes only the lowest set bit.
- R8: After a retry, be_req stays high until it is acknowledged. A repeat with the same address and direction issues no new back-end access. If the result has arrived, the repeat completes with tgt_rdy in cycle C+1 and returns the held data.
- R9: While an access that ended in retry is still unacknowledged, a claimed access to a different address gets tgt_retry in cycle C+1 and makes no back-end access.
- R10: In the cycle after tgt_rdy or tgt_retry, tgt_sel, tgt_rdy, tgt_retry and bus_ad_oe are low while tgt_ctl_oe is still high. In the cycle after that, tgt_ctl_oe is low.
- R11: Write data is sampled from bus_ad_in in cycle A+1 and appears on be_wdata with be_wr high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sub_en | input | 1 | Enables subtractive claim of unmatched addresses |
| bus_start | input | 1 | Address phase strobe, one cycle |
| bus_wr | input | 1 | Command direction, 1 = write, sampled with the address |
| bus_be | input | DW/8 | Byte lane enables, active high, sampled with the address |
| bus_ad_in | input | DW | Shared address/data lines as seen by the target |
| other_sel | input | 1 | Device-select from any other agent |
| bus_ad_out | output | DW | Read data driven onto the shared lines |
| bus_ad_oe | output | 1 | Output enable for bus_ad_out |
| tgt_sel | output | 1 | Device-select from this target |
| tgt_rdy | output | 1 | Target ready, data phase completes |
| tgt_retry | output | 1 | Retry, cycle ends without data |
| tgt_ctl_oe | output | 1 | Drive enable for tgt_sel, tgt_rdy and tgt_retry |
| be_req | output | 1 | Back-end request, held until acknowledged |
| be_wr | output | 1 | Back-end write flag |
| be_addr | output | DW | Back-end address |
| be_wdata | output | DW | Back-end write data |
| be_be | output | DW/8 | Back-end byte enables |
| be_legacy | output | 1 | Access came through the subtractive path |
| be_ack | input | 1 | Back-end acknowledge |
| be_rdata | input | DW | Back-end read data, valid with be_ack |

## Verification
The bench targets the edges of the acknowledge deadline. An acknowledge latency of seven must still give tgt_rdy in cycle C+8, and a latency of eight must give retry in that same cycle. An off-by-one counter would swap these two outcomes. Other agents' device-select is placed in each cycle of the decode window in turn. A target that samples only one of those cycles would claim on top of another device. Retry sequences follow the outcome of the held request. A same-address repeat must complete at once from the held data with the back-end access count unchanged. A different-address access made while the old request is still pending must be retried at once. A design that reissued requests would show extra back-end accesses or mixed-up data. Compatibility addresses are decoded with subtractive decode enabled to catch a design that forwards them with the legacy flag set. Ignored cycles with subtractive decode off are checked at tgt_sel and the back-end access count.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEC, ST_SUB, ST_DATA, ST_DONE, ST_REL
  } bt_state_t;
endpackage

// File: rtl/bt_win_decode.sv
module bt_win_decode #(
  parameter int AW = 32,
  parameter int NWIN = 2,
  parameter logic [NWIN*AW-1:0] WIN_BASE = '0,
  parameter logic [NWIN*8-1:0] WIN_BITS = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [NWIN-1:0] match;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam int B = int'(WIN_BITS[i*8 +: 8]);
    localparam logic [AW-1:0] MSK = ~((AW'(1) << B) - AW'(1));
    localparam logic [AW-1:0] BASE = WIN_BASE[i*AW +: AW];
    assign match[i] = ((addr ^ BASE) & MSK) == '0;
  end

  assign hit = |match;
endmodule

// File: rtl/bt_low_byte.sv
module bt_low_byte #(
  parameter int N = 4
) (
  input  logic [N-1:0] lanes,
  output logic [N-1:0] lowest
);
  logic [N:0] below;
  assign below[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_lane
    assign below[i+1] = below[i] | lanes[i];
    assign lowest[i]  = lanes[i] & ~below[i];
  end
endmodule

// File: rtl/bt_retry_buf.sv
module bt_retry_buf #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] start_addr,
  input  logic          start_wr,
  input  logic          ack_take,
  input  logic [DW-1:0] ack_data,
  input  logic          consume,
  input  logic [DW-1:0] cmp_addr,
  input  logic          cmp_wr,
  output logic          held,
  output logic          arrived,
  output logic          same,
  output logic [DW-1:0] data
);
  logic [DW-1:0] addr_q;
  logic          wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held    <= 1'b0;
      arrived <= 1'b0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      data    <= '0;
    end else begin
      if (ack_take) begin
        arrived <= 1'b1;
        data    <= ack_data;
      end
      if (start) begin
        held    <= 1'b1;
        arrived <= 1'b0;
        addr_q  <= start_addr;
        wr_q    <= start_wr;
      end
      if (consume) begin
        held    <= 1'b0;
        arrived <= 1'b0;
      end
    end
  end

  assign same = held && (addr_q == cmp_addr) && (wr_q == cmp_wr);
endmodule

// File: rtl/io_bus_target.sv
module io_bus_target
  import bt_pkg::*;
#(
  parameter int DW = 32,
  parameter int NWIN = 2,
  parameter logic [NWIN*DW-1:0] WIN_BASE = {32'h0000_0060, 32'h0000_E400},
  parameter logic [NWIN*8-1:0] WIN_BITS = {8'd4, 8'd6},
  parameter int DEADLINE = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_sub_en,
  input  logic            bus_start,
  input  logic            bus_wr,
  input  logic [DW/8-1:0] bus_be,
  input  logic [DW-1:0]   bus_ad_in,
  input  logic            other_sel,
  output logic [DW-1:0]   bus_ad_out,
  output logic            bus_ad_oe,
  output logic            tgt_sel,
  output logic            tgt_rdy,
  output logic            tgt_retry,
  output logic            tgt_ctl_oe,
  output logic            be_req,
  output logic            be_wr,
  output logic [DW-1:0]   be_addr,
  output logic [DW-1:0]   be_wdata,
  output logic [DW/8-1:0] be_be,
  output logic            be_legacy,
  input  logic            be_ack,
  input  logic [DW-1:0]   be_rdata
);
  localparam int BEW = DW / 8;
  localparam int CW = (DEADLINE > 1) ? $clog2(DEADLINE) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEADLINE - 1);

  bt_state_t     st;
  logic [DW-1:0] a_addr, a_wdata;
  logic          a_wr, a_hit, a_seen;
  logic [BEW-1:0] a_be;
  logic [CW-1:0] cnt;
  logic          busy_q;

  logic          win_hit;
  logic [BEW-1:0] low_be;
  logic          buf_held, buf_arrived, buf_same;
  logic [DW-1:0] buf_data;

  bt_win_decode #(.AW(DW), .NWIN(NWIN), .WIN_BASE(WIN_BASE), .WIN_BITS(WIN_BITS))
    u_dec (.addr(bus_ad_in), .hit(win_hit));

  bt_low_byte #(.N(BEW)) u_low (.lanes(a_be), .lowest(low_be));

  logic claim_go, claim_leg, busy_set, new_req, ack_take, have, consume;
  logic [DW-1:0] have_data;

  always_comb begin
    claim_leg = (st == ST_SUB);
    claim_go  = ((st == ST_DEC) && a_hit) ||
                ((st == ST_SUB) && !a_seen && !other_sel);
    busy_set  = claim_go && !buf_same && buf_held && !buf_arrived;
    new_req   = claim_go && !buf_same && !(buf_held && !buf_arrived);
    ack_take  = be_req && be_ack;
    have      = buf_arrived || ack_take;
    have_data = buf_arrived ? buf_data : be_rdata;
    consume   = (st == ST_DATA) && !busy_q && have;
  end

  bt_retry_buf #(.DW(DW)) u_buf (
    .clk(clk), .rst(rst),
    .start(new_req), .start_addr(a_addr), .start_wr(a_wr),
    .ack_take(ack_take), .ack_data(be_rdata), .consume(consume),
    .cmp_addr(a_addr), .cmp_wr(a_wr),
    .held(buf_held), .arrived(buf_arrived), .same(buf_same), .data(buf_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      a_addr     <= '0;
      a_wdata    <= '0;
      a_wr       <= 1'b0;
      a_be       <= '0;
      a_hit      <= 1'b0;
      a_seen     <= 1'b0;
      cnt        <= '0;
      busy_q     <= 1'b0;
      tgt_sel    <= 1'b0;
      tgt_rdy    <= 1'b0;
      tgt_retry  <= 1'b0;
      tgt_ctl_oe <= 1'b0;
      bus_ad_oe  <= 1'b0;
      bus_ad_out <= '0;
      be_req     <= 1'b0;
      be_wr      <= 1'b0;
      be_addr    <= '0;
      be_wdata   <= '0;
      be_be      <= '0;
      be_legacy  <= 1'b0;
    end else begin
      if (ack_take) be_req <= 1'b0;

      case (st)
        ST_IDLE: if (bus_start) begin
          a_addr <= bus_ad_in;
          a_wr   <= bus_wr;
          a_be   <= bus_be;
          a_hit  <= win_hit;
          st     <= ST_DEC;
        end
        ST_DEC: begin
          a_wdata <= bus_ad_in;
          a_seen  <= other_sel;
          if (a_hit)           st <= ST_DATA;
          else if (cfg_sub_en) st <= ST_SUB;
          else                 st <= ST_IDLE;
        end
        ST_SUB: st <= claim_go ? ST_DATA : ST_IDLE;
        ST_DATA: begin
          if (busy_q) begin
            tgt_retry <= 1'b1;
            st        <= ST_DONE;
          end else if (have) begin
            tgt_rdy    <= 1'b1;
            bus_ad_oe  <= !a_wr;
            bus_ad_out <= have_data;
            st         <= ST_DONE;
          end else if (cnt == LAST) begin
            tgt_retry <= 1'b1;
            st        <= ST_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DONE: begin
          tgt_sel   <= 1'b0;
          tgt_rdy   <= 1'b0;
          tgt_retry <= 1'b0;
          bus_ad_oe <= 1'b0;
          st        <= ST_REL;
        end
        ST_REL: begin
          tgt_ctl_oe <= 1'b0;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase

      if (claim_go) begin
        tgt_sel    <= 1'b1;
        tgt_ctl_oe <= 1'b1;
        cnt        <= '0;
        busy_q     <= busy_set;
      end

      if (new_req) begin
        be_req    <= 1'b1;
        be_wr     <= a_wr;
        be_addr   <= a_addr;
        be_wdata  <= (st == ST_DEC) ? bus_ad_in : a_wdata;
        be_be     <= claim_leg ? low_be : a_be;
        be_legacy <= claim_leg;
      end
    end
  end
endmodule

// File: rtl/bt_chk.sv
module bt_chk #(
  parameter int DW = 32,
  parameter int DEADLINE = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_ad_oe,
  input logic            tgt_sel,
  input logic            tgt_rdy,
  input logic            tgt_retry,
  input logic            tgt_ctl_oe,
  input logic            be_req,
  input logic            be_ack,
  input logic            be_legacy,
  input logic [DW/8-1:0] be_be
);
  localparam int WW = $clog2(DEADLINE + 2);
  logic [WW-1:0] wait_c;

  always_ff @(posedge clk) begin
    if (rst) wait_c <= '0;
    else if (tgt_sel && !tgt_rdy && !tgt_retry) wait_c <= wait_c + 1'b1;
    else wait_c <= '0;
  end

  // R6
  deadline_chk: assert property (@(posedge clk) disable iff (rst)
    wait_c <= WW'(DEADLINE));

  // R6
  done_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tgt_rdy, tgt_retry}));

  // R5
  drive_only_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ad_oe |-> tgt_rdy);

  // R5
  turnaround_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_rdy |-> $past(tgt_sel));

  // R10
  done_has_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_rdy || tgt_retry) |-> tgt_sel);

  // R10
  release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tgt_sel) |-> tgt_ctl_oe);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (be_req && !be_ack) |=> be_req);

  // R7
  legacy_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (be_req && be_legacy) |-> $onehot0(be_be));
endmodule

bind io_bus_target bt_chk #(.DW(DW), .DEADLINE(DEADLINE)) u_chk (
  .clk(clk), .rst(rst), .bus_ad_oe(bus_ad_oe), .tgt_sel(tgt_sel),
  .tgt_rdy(tgt_rdy), .tgt_retry(tgt_retry), .tgt_ctl_oe(tgt_ctl_oe),
  .be_req(be_req), .be_ack(be_ack), .be_legacy(be_legacy), .be_be(be_be)
);

// File: tb/test_io_bus_target.sv
`timescale 1ns/1ps
module test_io_bus_target;
  localparam int DW = 32;
  localparam int DL = 8;
  localparam logic [31:0] MAGIC = 32'h5A5A_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_sub_en = 1'b1, bus_start = 1'b0, bus_wr = 1'b0, other_sel = 1'b0;
  logic [3:0] bus_be = 4'h0;
  logic [DW-1:0] bus_ad_in = '0;
  logic [DW-1:0] bus_ad_out, be_addr, be_wdata;
  logic [DW-1:0] be_rdata = '0;
  logic bus_ad_oe, tgt_sel, tgt_rdy, tgt_retry, tgt_ctl_oe;
  logic be_req, be_wr, be_legacy;
  logic be_ack = 1'b0;
  logic [3:0] be_be;

  always #2.5 clk = ~clk;

  io_bus_target i_io_bus_target (
    .clk(clk), .rst(rst), .cfg_sub_en(cfg_sub_en), .bus_start(bus_start),
    .bus_wr(bus_wr), .bus_be(bus_be), .bus_ad_in(bus_ad_in), .other_sel(other_sel),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .tgt_sel(tgt_sel),
    .tgt_rdy(tgt_rdy), .tgt_retry(tgt_retry), .tgt_ctl_oe(tgt_ctl_oe),
    .be_req(be_req), .be_wr(be_wr), .be_addr(be_addr), .be_wdata(be_wdata),
    .be_be(be_be), .be_legacy(be_legacy), .be_ack(be_ack), .be_rdata(be_rdata)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // back-end model: acknowledge after lat cycles of request
  int lat = 0, k = 0, acc_cnt = 0;
  logic [3:0] last_be;
  logic last_leg, last_wr;
  logic [31:0] last_wd;
  always @(negedge clk) begin
    if (rst || !be_req) begin
      be_ack = 1'b0;
      k = 0;
    end else begin
      if (k >= lat && !be_ack) begin
        be_ack = 1'b1;
        be_rdata = be_addr ^ MAGIC;
        acc_cnt++;
        last_be = be_be;
        last_leg = be_legacy;
        last_wr = be_wr;
        last_wd = be_wdata;
      end else begin
        be_ack = 1'b0;
      end
      k++;
    end
  end

  // scoreboard queues
  bit q_rty[$];
  bit q_rd[$];
  logic [31:0] q_dat[$];
  int q_cyc[$];
  string q_tag[$];

  int rel_at = -10, sel_rise = -1;
  bit sel_seen = 0, sel_prev = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (tgt_sel) sel_seen = 1;
      if (tgt_sel && !sel_prev) sel_rise = cyc;
      sel_prev = tgt_sel;
      if (cyc == rel_at + 1) begin
        // R10 strobes inactive but still driven
        chk(!tgt_sel && !tgt_rdy && !tgt_retry && !bus_ad_oe && tgt_ctl_oe, "R10",
            "release cycle {sel,rdy,retry,oe,ctl_oe}",
            {27'd0, tgt_sel, tgt_rdy, tgt_retry, bus_ad_oe, tgt_ctl_oe}, 32'h1);
      end
      if (cyc == rel_at + 2)
        chk(!tgt_ctl_oe, "R10", "ctl_oe after release", {31'd0, tgt_ctl_oe}, 32'h0);
      if (tgt_rdy || tgt_retry) begin
        if (q_cyc.size() == 0) begin
          chk(0, "R3", "unexpected completion", {31'd0, tgt_rdy}, 32'h0);
        end else begin
          bit e_r, e_rd;
          logic [31:0] e_d;
          int e_c;
          string tg;
          e_r = q_rty.pop_front();
          e_rd = q_rd.pop_front();
          e_d = q_dat.pop_front();
          e_c = q_cyc.pop_front();
          tg = q_tag.pop_front();
          chk(cyc == e_c, tg, "completion cycle", cyc, e_c);
          chk(tgt_retry == e_r, tg, "retry flag", {31'd0, tgt_retry}, {31'd0, e_r});
          if (!e_r && e_rd)
            chk(bus_ad_oe && bus_ad_out == e_d, tg, "read data on bus", bus_ad_out, e_d);
          else
            chk(!bus_ad_oe, tg, "no bus drive", {31'd0, bus_ad_oe}, 32'h0);
          rel_at = cyc;
        end
      end
    end
  end

  // driver: issues one bus access and pushes the expected completion
  task automatic xfer(input logic [31:0] addr, input bit wr, input logic [3:0] be,
                      input logic [31:0] wd, input int oth, input bit claim,
                      input int coff, input bit rty, input int off,
                      input logic [31:0] dat, input string tag);
    int a;
    @(negedge clk);
    a = cyc;
    sel_seen = 0;
    sel_rise = -1;
    bus_start = 1'b1; bus_ad_in = addr; bus_wr = wr; bus_be = be;
    if (claim) begin
      q_rty.push_back(rty); q_rd.push_back(!wr); q_dat.push_back(dat);
      q_cyc.push_back(a + off); q_tag.push_back(tag);
    end
    @(negedge clk);
    bus_start = 1'b0; bus_ad_in = wd; other_sel = (oth == 1);
    @(negedge clk);
    other_sel = (oth == 2);
    @(negedge clk);
    other_sel = 1'b0;
    while (cyc < a + off + 3) @(negedge clk);
    if (claim) chk(sel_rise == a + coff, tag, "claim cycle", sel_rise, a + coff);
    else chk(!sel_seen, tag, "no claim", {31'd0, sel_seen}, 32'h0);
  endtask

  function automatic int done_off(input int coff, input int l);
    return (l <= DL - 1) ? coff + l + 1 : coff + DL;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({tgt_sel, tgt_rdy, tgt_retry, tgt_ctl_oe, bus_ad_oe, be_req} == 6'b0, "R1",
        "idle outputs", {26'd0, tgt_sel, tgt_rdy, tgt_retry, tgt_ctl_oe, bus_ad_oe, be_req}, 32'h0);

    // R2 R5 positive read, zero latency: 4-clock access
    lat = 0;
    xfer(32'h0000_E404, 0, 4'hF, 0, 0, 1, 2, 0, done_off(2, 0), 32'h0000_E404 ^ MAGIC, "R5");
    chk(last_leg == 0 && last_be == 4'hF, "R2", "positive back-end {leg,be}",
        {27'd0, last_leg, last_be}, 32'h0F);

    // R11 R7 positive write
    lat = 2;
    xfer(32'h0000_E410, 1, 4'b0011, 32'hDEAD_BEEF, 0, 1, 2, 0, done_off(2, 2), 0, "R11");
    chk(last_wr && last_wd == 32'hDEAD_BEEF, "R11", "write data", last_wd, 32'hDEAD_BEEF);
    chk(last_be == 4'b0011, "R7", "positive lanes unchanged", {28'd0, last_be}, 32'h3);

    // R2 compatibility window stays positive with subtractive on
    lat = 1;
    xfer(32'h0000_0064, 0, 4'b0001, 0, 0, 1, 2, 0, done_off(2, 1), 32'h0000_0064 ^ MAGIC, "R2");
    chk(last_leg == 0, "R2", "compat not legacy", {31'd0, last_leg}, 32'h0);

    // R3 R7 subtractive read
    lat = 0;
    xfer(32'h0000_03F8, 0, 4'b1100, 0, 0, 1, 3, 0, done_off(3, 0), 32'h0000_03F8 ^ MAGIC, "R3");
    chk(last_leg == 1 && last_be == 4'b0100, "R7", "legacy single lane {leg,be}",
        {27'd0, last_leg, last_be}, 32'h14);

    // R3 another agent claims in either window cycle
    base = acc_cnt;
    xfer(32'h0000_03F9, 0, 4'h1, 0, 2, 0, 0, 0, 6, 0, "R3");
    xfer(32'h0000_03FA, 0, 4'h1, 0, 1, 0, 0, 0, 6, 0, "R3");
    chk(acc_cnt == base, "R3", "no back-end access", acc_cnt, base);

    // R4 subtractive disabled
    cfg_sub_en = 1'b0;
    xfer(32'h0000_03F8, 0, 4'h1, 0, 0, 0, 0, 0, 6, 0, "R4");
    chk(acc_cnt == base, "R4", "ignored cycle no access", acc_cnt, base);
    cfg_sub_en = 1'b1;

    // R6 boundary: latency 7 completes, latency 8 retries
    lat = 7;
    xfer(32'h0000_E420, 0, 4'hF, 0, 0, 1, 2, 0, done_off(2, 7), 32'h0000_E420 ^ MAGIC, "R6");
    lat = 8;
    base = acc_cnt;
    xfer(32'h0000_E408, 0, 4'hF, 0, 0, 1, 2, 1, done_off(2, 8), 0, "R6");
    // R8 repeat completes from held data
    lat = 0;
    xfer(32'h0000_E408, 0, 4'hF, 0, 0, 1, 2, 0, 3, 32'h0000_E408 ^ MAGIC, "R8");
    chk(acc_cnt == base + 1, "R8", "single back-end access", acc_cnt, base + 1);

    // R9 different address while request outstanding
    lat = 20;
    base = acc_cnt;
    xfer(32'h0000_E414, 0, 4'hF, 0, 0, 1, 2, 1, done_off(2, 20), 0, "R6");
    xfer(32'h0000_E418, 0, 4'hF, 0, 0, 1, 2, 1, 3, 0, "R9");
    chk(acc_cnt == base, "R9", "no access while busy", acc_cnt, base);
    repeat (8) @(negedge clk);
    xfer(32'h0000_E414, 0, 4'hF, 0, 0, 1, 2, 0, 3, 32'h0000_E414 ^ MAGIC, "R8");
    chk(acc_cnt == base + 1, "R8", "late ack kept", acc_cnt, base + 1);
    chk(q_cyc.size() == 0, "R5", "all completions seen", q_cyc.size(), 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule